// File: doc/BRIEF.md
# Bit-Serial Header Check Alignment Hunter

This block works on a serial line that carries fixed-size cells but no framing pulse. It looks for the place in the bit stream where a cell header begins. For that it keeps the last 40 accepted bits. On every accepted bit it treats the oldest 32 of them as a candidate header. It computes a check octet over that candidate and compares the octet with the 8 bits that follow. If they differ, the candidate simply moves on by one bit position with the next accepted bit. The search therefore tries every bit offset in turn, and does not step a whole byte at a time.

On the first position that matches, the block declares alignment and raises a one-cycle header-start pulse. It also reports where the byte boundary lies in the stream, as an offset from 0 to 7. From then on it emits a byte strobe every eight accepted bits, counted from the matched boundary. A downstream cell delineation stage uses these outputs. When that stage loses delineation it asserts the restart input, and the bit-serial search starts again from empty.

Top module: `hec_align_hunter`

## Requirements
- R1: Once reset has been released, aligned_o is 0, offset_o is 0, and hdr_start_o and byte_stb_o are both 0.
- R2: After a reset or a restart, no match can be declared until 40 bits have been accepted.
- R3: A position matches when the 8 most recently accepted bits equal the check octet of the 32 bits accepted just before them, XORed with 0x55. The check octet is the remainder of that 32-bit value times x^8 divided by x^8+x^2+x+1, with the bit accepted first taken as the most significant bit. aligned_o rises in the cycle after the clock edge that accepts the last bit of the matching octet.
- R4: While hunting, every accepted bit moves the candidate window by exactly one bit. The first matching position is found whatever its bit offset.
- R5: On a match, offset_o takes the value (index of the first header bit) mod 8, where accepted bits are numbered from 0 after reset or restart. The value holds while the block stays aligned.
- R6: hdr_start_o is a one-cycle pulse in the same cycle in which aligned_o rises. It occurs exactly once for each lock.
- R7: While aligned, byte_stb_o pulses for one cycle after every 8th accepted bit that follows the matched bit. It never coincides with hdr_start_o.
- R8: A cycle with bit_valid_i low changes nothing. aligned_o holds, and no pulse appears in the following cycle.
- R9: restart_i clears aligned_o and offset_o in the next cycle and empties the window. A bit presented in the same cycle as restart_i is discarded.
- R10: Once aligned, the block stops searching. aligned_o stays high and later matching patterns give no further header pulse until a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bit_i | input | 1 | Serial line bit |
| bit_valid_i | input | 1 | bit_i is accepted on this clock edge |
| restart_i | input | 1 | Drop alignment and restart the search (loss of delineation) |
| aligned_o | output | 1 | Byte and cell alignment has been found |
| offset_o | output | 3 | Bit offset of the found byte boundary (0 to 7) |
| hdr_start_o | output | 1 | One-cycle pulse marking the matched header |
| byte_stb_o | output | 1 | One-cycle pulse after each further byte once aligned |

## Verification
The bench builds the block with its default 32-bit window and 8-bit check octet. With these values a match can lie at any of the eight bit offsets, and an independent long-division model in the bench can scan every position of a short stream. The sweep places a valid header behind zero runs of every length from 0 to 23 bits and varies the header contents. It streams the bits with and without idle gaps, and in some streams it repeats the header in the payload. Each sweep therefore covers the earliest possible match, all offsets, gap handling and re-lock suppression. Separate runs present a bit in the same cycle as a restart and split a valid header across a restart.

// File: rtl/hah_pkg.sv
`timescale 1ns/1ps
package hah_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_LOCK = 1'b1
  } hunt_state_e;

endpackage

// File: rtl/hah_rst_sync.sv
`timescale 1ns/1ps
module hah_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= 2'b00;
    end else begin
      pipe_q <= {pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = pipe_q[1];

endmodule

// File: rtl/hah_shift_window.sv
`timescale 1ns/1ps
module hah_shift_window #(
  parameter int TOTAL = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [TOTAL-1:0] win_nx_o,
  output logic             full_nx_o
);

  localparam int FILL_W = $clog2(TOTAL + 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(TOTAL);

  logic [TOTAL-1:0]  sr_q, sr_nx;
  logic [FILL_W-1:0] fill_q, fill_nx;
  logic              upd_en;

  // next-state
  always_comb begin
    sr_nx   = sr_q;
    fill_nx = fill_q;
    if (clear_i) begin
      sr_nx   = '0;
      fill_nx = '0;
    end else if (shift_i) begin
      sr_nx = {sr_q[TOTAL-2:0], bit_i};
      if (fill_q != FILL_MAX) begin
        fill_nx = fill_q + 1'b1;
      end
    end
  end

  assign upd_en = clear_i | shift_i;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      fill_q <= '0;
    end else if (upd_en) begin
      sr_q   <= sr_nx;
      fill_q <= fill_nx;
    end
  end

  assign win_nx_o  = sr_nx;
  assign full_nx_o = (fill_nx == FILL_MAX);

endmodule

// File: rtl/hah_crc_match.sv
`timescale 1ns/1ps
module hah_crc_match #(
  parameter int          WIN   = 32,
  parameter int          CHK   = 8,
  parameter int unsigned POLY  = 'h07,
  parameter int unsigned COSET = 'h55
) (
  input  logic [WIN+CHK-1:0] vec_i,
  output logic               match_o
);

  localparam logic [CHK-1:0] POLY_V  = CHK'(POLY);
  localparam logic [CHK-1:0] COSET_V = CHK'(COSET);

  logic [CHK-1:0] rem;
  logic           fb;

  // serial remainder over the window, oldest bit first
  always_comb begin
    rem = '0;
    fb  = 1'b0;
    for (int i = WIN - 1; i >= 0; i--) begin
      fb  = rem[CHK-1] ^ vec_i[CHK+i];
      rem = {rem[CHK-2:0], 1'b0};
      if (fb) begin
        rem = rem ^ POLY_V;
      end
    end
    match_o = ((rem ^ COSET_V) == vec_i[CHK-1:0]);
  end

endmodule

// File: rtl/hah_phase_ctr.sv
`timescale 1ns/1ps
module hah_phase_ctr #(
  parameter int CHK  = 8,
  parameter int PH_W = $clog2(CHK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_i,
  input  logic            load0_i,
  input  logic            step_i,
  output logic [PH_W-1:0] ph_o,
  output logic            wrap_o
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CHK - 1);

  logic [PH_W-1:0] ph_q, ph_nx;
  logic            ph_en;

  always_comb begin
    ph_nx = ph_q;
    if (clear_i || load0_i) begin
      ph_nx = '0;
    end else if (step_i) begin
      ph_nx = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end
  end

  assign ph_en = clear_i | load0_i | step_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (ph_en) begin
      ph_q <= ph_nx;
    end
  end

  assign ph_o   = ph_q;
  assign wrap_o = step_i && !clear_i && (ph_q == PH_LAST);

endmodule

// File: rtl/hah_ctrl.sv
`timescale 1ns/1ps
module hah_ctrl
  import hah_pkg::*;
#(
  parameter int WIN   = 32,
  parameter int CHK   = 8,
  parameter int OFF_W = $clog2(CHK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             bit_valid_i,
  input  logic             found_i,
  input  logic             wrap_i,
  input  logic [OFF_W-1:0] ph_i,
  output logic             hunting_o,
  output logic             load0_o,
  output logic             aligned_o,
  output logic [OFF_W-1:0] offset_o,
  output logic             hdr_start_o,
  output logic             byte_stb_o
);

  localparam int LMOD = (WIN + CHK) % CHK;

  hunt_state_e      st_q, st_nx;
  logic [OFF_W-1:0] off_q, off_nx;
  logic             hdr_q, hdr_nx;
  logic             stb_q, stb_nx;
  logic             accept;
  logic             hit;
  int               off_calc;

  assign accept  = bit_valid_i && !restart_i;
  assign hit     = (st_q == ST_HUNT) && accept && found_i;
  assign off_calc = (int'(ph_i) + 1 + CHK - LMOD) % CHK;

  // next-state
  always_comb begin
    st_nx  = st_q;
    off_nx = off_q;
    hdr_nx = 1'b0;
    stb_nx = 1'b0;
    if (restart_i) begin
      st_nx  = ST_HUNT;
      off_nx = '0;
    end else begin
      unique case (st_q)
        ST_HUNT: begin
          if (hit) begin
            st_nx  = ST_LOCK;
            off_nx = OFF_W'(off_calc);
            hdr_nx = 1'b1;
          end
        end
        ST_LOCK: begin
          stb_nx = wrap_i;
        end
        default: st_nx = ST_HUNT;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      off_q <= '0;
      hdr_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      st_q  <= st_nx;
      off_q <= off_nx;
      hdr_q <= hdr_nx;
      stb_q <= stb_nx;
    end
  end

  assign hunting_o   = (st_q == ST_HUNT);
  assign load0_o     = hit;
  assign aligned_o   = (st_q == ST_LOCK);
  assign offset_o    = off_q;
  assign hdr_start_o = hdr_q;
  assign byte_stb_o  = stb_q;

endmodule

// File: rtl/hec_align_hunter.sv
`timescale 1ns/1ps
module hec_align_hunter #(
  parameter int          WIN_BITS = 32,
  parameter int          CHK_BITS = 8,
  parameter int unsigned POLY     = 'h07,
  parameter int unsigned COSET    = 'h55,
  parameter int          OFF_W    = $clog2(CHK_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_i,
  input  logic             bit_valid_i,
  input  logic             restart_i,
  output logic             aligned_o,
  output logic [OFF_W-1:0] offset_o,
  output logic             hdr_start_o,
  output logic             byte_stb_o
);

  localparam int TOTAL = WIN_BITS + CHK_BITS;

  logic             rst_sync_n;
  logic [TOTAL-1:0] win_nx;
  logic             full_nx;
  logic             match;
  logic             found;
  logic             hunting;
  logic             load0;
  logic             shift_en;
  logic             step;
  logic [OFF_W-1:0] ph;
  logic             wrap;

  hah_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign step     = bit_valid_i && !restart_i;
  assign shift_en = step && hunting;

  hah_shift_window #(.TOTAL(TOTAL)) u_win (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clear_i   (restart_i),
    .shift_i   (shift_en),
    .bit_i     (bit_i),
    .win_nx_o  (win_nx),
    .full_nx_o (full_nx)
  );

  hah_crc_match #(
    .WIN   (WIN_BITS),
    .CHK   (CHK_BITS),
    .POLY  (POLY),
    .COSET (COSET)
  ) u_crc (
    .vec_i   (win_nx),
    .match_o (match)
  );

  assign found = match && full_nx;

  hah_phase_ctr #(.CHK(CHK_BITS), .PH_W(OFF_W)) u_ph (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear_i (restart_i),
    .load0_i (load0),
    .step_i  (step),
    .ph_o    (ph),
    .wrap_o  (wrap)
  );

  hah_ctrl #(.WIN(WIN_BITS), .CHK(CHK_BITS), .OFF_W(OFF_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .restart_i   (restart_i),
    .bit_valid_i (bit_valid_i),
    .found_i     (found),
    .wrap_i      (wrap),
    .ph_i        (ph),
    .hunting_o   (hunting),
    .load0_o     (load0),
    .aligned_o   (aligned_o),
    .offset_o    (offset_o),
    .hdr_start_o (hdr_start_o),
    .byte_stb_o  (byte_stb_o)
  );

endmodule

// File: rtl/hah_checker.sv
`timescale 1ns/1ps
module hah_checker #(
  parameter int TOTAL = 40,
  parameter int OFF_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid_i,
  input logic             restart_i,
  input logic             aligned_o,
  input logic [OFF_W-1:0] offset_o,
  input logic             hdr_start_o,
  input logic             byte_stb_o
);

  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TOTAL);

  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (restart_i) begin
      seen_q <= '0;
    end else if (bit_valid_i && seen_q != CNT_MAX) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  assert_fill_before_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_start_o |-> (seen_q == CNT_MAX));

  assert_offset_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned_o && !hdr_start_o) |-> $stable(offset_o));

  assert_hdr_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_start_o |-> (aligned_o && !$past(aligned_o)));

  assert_pulses_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_start_o |-> !byte_stb_o);

  assert_gap_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid_i && !restart_i) |=> ($stable(aligned_o) && !hdr_start_o && !byte_stb_o));

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (!aligned_o && offset_o == '0 && !hdr_start_o && !byte_stb_o));

  assert_lock_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (aligned_o && !restart_i) |=> aligned_o);

endmodule

bind hec_align_hunter hah_checker #(
  .TOTAL (WIN_BITS + CHK_BITS),
  .OFF_W (OFF_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .bit_valid_i (bit_valid_i),
  .restart_i   (restart_i),
  .aligned_o   (aligned_o),
  .offset_o    (offset_o),
  .hdr_start_o (hdr_start_o),
  .byte_stb_o  (byte_stb_o)
);

// File: tb/hec_align_hunter_test.sv
`timescale 1ns/1ps
module hec_align_hunter_test;

  logic       clk;
  logic       rst_n;
  logic       bit_i;
  logic       bit_valid_i;
  logic       restart_i;
  logic       aligned_o;
  logic [2:0] offset_o;
  logic       hdr_start_o;
  logic       byte_stb_o;

  int nchk;
  int nfail;
  logic sbits [0:255];

  hec_align_hunter uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_i       (bit_i),
    .bit_valid_i (bit_valid_i),
    .restart_i   (restart_i),
    .aligned_o   (aligned_o),
    .offset_o    (offset_o),
    .hdr_start_o (hdr_start_o),
    .byte_stb_o  (byte_stb_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int got, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // remainder of a 40-bit value modulo x^8+x^2+x+1
  function automatic logic [7:0] rem40(input logic [39:0] v);
    logic [39:0] w;
    w = v;
    for (int i = 39; i >= 8; i--) begin
      if (w[i]) w = w ^ (40'h107 << (i - 8));
    end
    return w[7:0];
  endfunction

  function automatic logic [7:0] hec_of(input logic [31:0] h);
    return rem40({h, 8'h00}) ^ 8'h55;
  endfunction

  // index of the bit completing the first matching 40-bit span, or -1
  function automatic int ref_first(input int nb);
    for (int n = 39; n < nb; n++) begin
      logic [39:0] v;
      for (int j = 0; j < 40; j++) v[39-j] = sbits[n-39+j];
      if ((rem40({v[39:8], 8'h00}) ^ 8'h55) == v[7:0]) return n;
    end
    return -1;
  endfunction

  task automatic put_byte(input int pos, input logic [7:0] b);
    for (int j = 0; j < 8; j++) sbits[pos+j] = b[7-j];
  endtask

  task automatic do_restart(input bit with_bit);
    @(negedge clk);
    restart_i   = 1'b1;
    bit_valid_i = with_bit;
    bit_i       = 1'b1;
    @(posedge clk);
    @(negedge clk);
    restart_i   = 1'b0;
    bit_valid_i = 1'b0;
    chk(aligned_o == 1'b0 && offset_o == 3'd0, "R9", "cleared after restart",
        {aligned_o, offset_o}, 0);
  endtask

  task automatic run_stream(input int nb, input int gapmod, input bit rs_bit,
                            input bit relock_probe, input string tag);
    int m;
    int e_al, e_hdr, e_stb, e_gap;
    int got_off;
    m = ref_first(nb);
    e_al = 0; e_hdr = 0; e_stb = 0; e_gap = 0; got_off = -1;
    do_restart(rs_bit);
    for (int i = 0; i < nb; i++) begin
      bit x_al, x_hdr, x_stb;
      bit_i       = sbits[i];
      bit_valid_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bit_valid_i = 1'b0;
      x_al  = (m >= 0) && (i >= m);
      x_hdr = (i == m);
      x_stb = (m >= 0) && (i > m) && ((i - m) % 8 == 0);
      if (aligned_o != x_al) e_al++;
      if (hdr_start_o != x_hdr) e_hdr++;
      if (byte_stb_o != x_stb) e_stb++;
      if (i == m) got_off = int'(offset_o);
      if (gapmod > 0 && (i % gapmod) == gapmod - 1) begin
        bit_i = ~sbits[i];
        @(posedge clk);
        @(negedge clk);
        if (aligned_o != x_al || hdr_start_o || byte_stb_o) e_gap++;
      end
    end
    chk(m >= 0 && e_al == 0, "R3", {tag, " aligned timing mismatches"}, e_al, 0);
    chk(m >= 0 && got_off == ((m - 39) % 8), "R5", {tag, " offset"},
        got_off, (m - 39) % 8);
    chk(e_hdr == 0, "R6", {tag, " header pulse mismatches"}, e_hdr, 0);
    chk(e_stb == 0, "R7", {tag, " byte strobe mismatches"}, e_stb, 0);
    if (gapmod > 0) chk(e_gap == 0, "R8", {tag, " idle-cycle mismatches"}, e_gap, 0);
    if (relock_probe) chk(aligned_o == 1'b1 && e_hdr == 0, "R10",
                          {tag, " lock kept over repeated header"}, aligned_o, 1);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    nchk = 0;
    nfail = 0;
    rst_n = 1'b0;
    bit_i = 1'b0;
    bit_valid_i = 1'b0;
    restart_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(aligned_o == 1'b0, "R1", "aligned after reset", aligned_o, 0);
    chk(offset_o == 3'd0, "R1", "offset after reset", offset_o, 0);
    chk(!hdr_start_o && !byte_stb_o, "R1", "pulses after reset",
        {hdr_start_o, byte_stb_o}, 0);

    // sweep: every bit offset, several prefix lengths and header contents (R4)
    for (int off = 0; off < 8; off++) begin
      for (int var_i = 0; var_i < 3; var_i++) begin
        int pre, nb;
        logic [31:0] hdr;
        string tag;
        pre = off + 8 * var_i;
        hdr = {8'(8'h13 * (off + 1)), 8'(8'h5A ^ var_i), 8'(off * 37 + var_i),
               8'(8'hC0 | off)};
        for (int k = 0; k < pre; k++) sbits[k] = 1'b0;
        put_byte(pre, hdr[31:24]);
        put_byte(pre + 8, hdr[23:16]);
        put_byte(pre + 16, hdr[15:8]);
        put_byte(pre + 24, hdr[7:0]);
        put_byte(pre + 32, hec_of(hdr));
        if (var_i == 2) begin
          put_byte(pre + 40, hdr[31:24]);
          put_byte(pre + 48, hdr[23:16]);
          put_byte(pre + 56, hdr[15:8]);
          put_byte(pre + 64, hdr[7:0]);
          put_byte(pre + 72, hec_of(hdr));
          nb = pre + 80;
        end else begin
          for (int k = 0; k < 4; k++) put_byte(pre + 40 + 8 * k, 8'(8'hA5 + 29 * k + off));
          nb = pre + 72;
        end
        $sformat(tag, "R4 off=%0d var=%0d", off, var_i);
        run_stream(nb, (var_i == 1) ? 3 : 0, 1'b0, var_i == 2, tag);
      end
    end

    // R9: a bit offered together with restart is dropped; R2: earliest match at 40 bits
    begin
      logic [31:0] hdr;
      hdr = 32'h0F1E_2D3C;
      put_byte(0, hdr[31:24]);
      put_byte(8, hdr[23:16]);
      put_byte(16, hdr[15:8]);
      put_byte(24, hdr[7:0]);
      put_byte(32, hec_of(hdr));
      put_byte(40, 8'h66);
      run_stream(48, 0, 1'b1, 1'b0, "R9 bit with restart, R2 first 40 bits");
    end

    // R2: a valid header split by a restart must not match
    begin
      int e_split;
      e_split = 0;
      do_restart(1'b0);
      for (int i = 0; i < 20; i++) begin
        bit_i = sbits[i]; bit_valid_i = 1'b1;
        @(posedge clk); @(negedge clk);
        bit_valid_i = 1'b0;
      end
      do_restart(1'b0);
      for (int i = 20; i < 40; i++) begin
        bit_i = sbits[i]; bit_valid_i = 1'b1;
        @(posedge clk); @(negedge clk);
        bit_valid_i = 1'b0;
        if (aligned_o || hdr_start_o) e_split++;
      end
      chk(e_split == 0, "R2", "no match from bits before restart", e_split, 0);
    end

    // R9: restart drops an established lock
    begin
      run_stream(48, 0, 1'b0, 1'b0, "R9 relock before drop");
      do_restart(1'b0);
      chk(!hdr_start_o && !byte_stb_o, "R9", "no pulses after restart",
          {hdr_start_o, byte_stb_o}, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule